// File: doc/BRIEF.md
# Tile Video Controller Processor Port

This block is the side of a tile-based video controller that faces the host processor. The processor sees two byte-wide ports, each with its own read strobe and write strobe. The **command port** takes two-byte commands and returns a status byte when read. The **data port** moves bytes into and out of either the video memory or the colour table, depending on which pointer the last command selected.

A command is always two writes. The first write is held in a staging latch. The second write carries a 2-bit opcode in its top bits, and that opcode decides what the staged byte becomes:

- a 14-bit video memory pointer,
- a write into one of sixteen internal configuration registers,
- a 5-bit colour table pointer.

Every data-port access advances the selected pointer by one. Rendering, sprite logic and video timing sit elsewhere. They report events to this block through three set pulses, and they read the configuration registers through a select/value pair and two decoded table bases.

The video memory pointer is always 14 bits wide. The storage behind it has 2^`VRAM_AW` bytes. The default build holds 2 KB and mirrors it across the 16 KB pointer space; setting `VRAM_AW` to 14 gives the full 16 KB.

Top module: `vdp_cpu_port`

## Requirements
- R1: A command takes effect only on its second write. After a single command-port write, the video memory pointer, the colour pointer and the registers keep their previous values.
- R2: When the second byte has bits 7:6 equal to 00 or 01, the video memory pointer becomes {second[5:0], first[7:0]}.
- R3: When the second byte has bits 7:6 equal to 10, configuration register second[3:0] takes the first byte. The name table base output is {reg2[3:1], 11 zero bits}. The sprite table base output is {reg5[6:1], 8 zero bits}. Register N can be read on `reg_val` two cycles after `reg_sel` = N is applied.
- R4: When the second byte has bits 7:6 equal to 11, the colour pointer becomes first[4:0].
- R5: Colour entries store 6 bits. A data-port write keeps wdata[5:0]. A data-port read of an entry returns it with bits 7:6 forced to zero.
- R6: Each data-port read or write advances the active pointer by one. The video memory pointer wraps from 0x3FFF to 0x0000, and the colour pointer wraps from 31 to 0.
- R7: A data-port access or a status read that arrives while a first command byte is staged discards that byte. The next command-port write is then treated as a new first byte.
- R8: A status read returns bit 7 = frame flag, bit 6 = line flag, bit 5 = collision flag, and bits 4:0 = 0. The read clears the frame and line flags. The collision flag stays set until reset.
- R9: If a set pulse arrives in the same cycle as a status read, that flag is set afterwards, and the byte returned by the read shows the flag's value from before that cycle.
- R10: Reset clears both pointers, the staged byte, colour selection and all flags. It sets reg2 = 0x0E and reg5 = 0x7E, so the name table base is 0x3800 and the sprite table base is 0x3F00. All other registers reset to 0x00.
- R11: `irq` is high exactly while the frame flag is set and reg1 bit 5 is 1.
- R12: Read data appears on `rdata`, with `rvalid` high, in the cycle after the read strobe. `rvalid` is low in every other cycle.
- R13: Data-port accesses go to the colour table only when the most recent complete command used opcode 11. After any other complete command they go to video memory.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| ctrl_wr | input | 1 | Command port write strobe |
| ctrl_rd | input | 1 | Status read strobe |
| data_wr | input | 1 | Data port write strobe |
| data_rd | input | 1 | Data port read strobe |
| wdata | input | 8 | Write byte for either port |
| rdata | output | 8 | Read byte, valid while rvalid |
| rvalid | output | 1 | Read data valid |
| frame_set | input | 1 | Frame flag set pulse |
| line_set | input | 1 | Line flag set pulse |
| coll_set | input | 1 | Collision flag set pulse |
| irq | output | 1 | Frame interrupt request |
| reg_sel | input | 4 | Configuration register select |
| reg_val | output | 8 | Selected register value, registered |
| name_base | output | 14 | Name table base address |
| sprite_base | output | 14 | Sprite table base address |

## Verification
A status read can fall in the same cycle as a set pulse from the renderer. Clearing the flag and setting it then compete for the same flop.

The bench provokes this by raising `frame_set` or `line_set` together with `ctrl_rd`, both while the flag is clear and while it is already set. It judges the result by two things: the byte returned in that read must match the prior state, and the next status read must show the flag still set.

A second overlap is a data or status access arriving between the two halves of a command. It is judged by reading back through the data port which address was actually used.

// File: rtl/vdp_port_pkg.sv
package vdp_port_pkg;

  // Opcode carried in bits 7:6 of the second command byte.
  typedef enum logic [1:0] {
    OP_VADDR_A = 2'b00,
    OP_VADDR_B = 2'b01,
    OP_REGWR   = 2'b10,
    OP_COLOUR  = 2'b11
  } cmd_op_e;

  // Which registered source feeds the read data output.
  typedef enum logic [1:0] {
    SRC_VRAM = 2'b00,
    SRC_PAL  = 2'b01,
    SRC_STAT = 2'b10
  } rd_src_e;

endpackage

// File: rtl/vdp_cmd_decoder.sv
module vdp_cmd_decoder
  import vdp_port_pkg::*;
#(
  parameter int unsigned DW     = 8,
  parameter int unsigned PTR_W  = 14,
  parameter int unsigned PAL_AW = 5,
  parameter int unsigned REG_AW = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              ctrl_wr,
  input  logic              ctrl_rd,
  input  logic              data_wr,
  input  logic              data_rd,
  input  logic [DW-1:0]     wdata,
  output logic [PTR_W-1:0]  vram_ptr,
  output logic [PAL_AW-1:0] pal_ptr,
  output logic              pal_sel,
  output logic              pending,
  output logic              reg_we,
  output logic [REG_AW-1:0] reg_idx,
  output logic [DW-1:0]     reg_data
);

  localparam int unsigned HI_W = PTR_W - DW;

  logic [DW-1:0] low_q;
  logic          data_acc;
  logic [1:0]    op;

  assign data_acc = data_wr | data_rd;
  assign op       = wdata[DW-1 -: 2];

  // Register write is decoded straight from the completing byte
  assign reg_we   = ctrl_wr & pending & (op == OP_REGWR);
  assign reg_idx  = wdata[REG_AW-1:0];
  assign reg_data = low_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      low_q    <= '0;
      pending  <= 1'b0;
      vram_ptr <= '0;
      pal_ptr  <= '0;
      pal_sel  <= 1'b0;
    end else if (ctrl_wr) begin
      if (!pending) begin
        low_q   <= wdata;
        pending <= 1'b1;
      end else begin
        pending <= 1'b0;
        case (op)
          OP_VADDR_A, OP_VADDR_B: begin
            vram_ptr <= {wdata[HI_W-1:0], low_q};
            pal_sel  <= 1'b0;
          end
          OP_REGWR: pal_sel <= 1'b0;
          default: begin
            pal_ptr <= low_q[PAL_AW-1:0];
            pal_sel <= 1'b1;
          end
        endcase
      end
    end else if (ctrl_rd) begin
      pending <= 1'b0;
    end else if (data_acc) begin
      pending <= 1'b0;
      if (pal_sel) pal_ptr  <= pal_ptr + 1'b1;
      else         vram_ptr <= vram_ptr + 1'b1;
    end
  end

endmodule

// File: rtl/vdp_bram.sv
module vdp_bram #(
  parameter int unsigned AW = 11,
  parameter int unsigned DW = 8
) (
  input  logic          clk,
  input  logic          we,
  input  logic          re,
  input  logic [AW-1:0] addr,
  input  logic [DW-1:0] din,
  output logic [DW-1:0] q
);

  localparam int unsigned DEPTH = 1 << AW;

  logic [DW-1:0] mem [DEPTH];

  // Single port, read-first, registered output: infers a block RAM
  always_ff @(posedge clk) begin
    if (we) mem[addr] <= din;
    if (re) q <= mem[addr];
  end

endmodule

// File: rtl/vdp_status_flags.sv
module vdp_status_flags #(
  parameter int unsigned NFLAG = 3
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             rd,
  input  logic [NFLAG-1:0] set_in,
  input  logic [NFLAG-1:0] clr_on_rd,
  output logic [NFLAG-1:0] flag_q,
  output logic [NFLAG-1:0] snap_q
);

  always_ff @(posedge clk) begin
    if (rst) snap_q <= '0;
    else if (rd) snap_q <= flag_q;
  end

  for (genvar i = 0; i < NFLAG; i++) begin : g_flag
    always_ff @(posedge clk) begin
      if (rst)                      flag_q[i] <= 1'b0;
      else if (set_in[i])           flag_q[i] <= 1'b1;
      else if (rd && clr_on_rd[i])  flag_q[i] <= 1'b0;
    end
  end

endmodule

// File: rtl/vdp_reg_bank.sv
module vdp_reg_bank #(
  parameter int unsigned DW       = 8,
  parameter int unsigned REG_AW   = 4,
  parameter int unsigned NAME_IDX = 2,
  parameter int unsigned SPR_IDX  = 5,
  parameter logic [7:0]  NAME_RST = 8'h0E,
  parameter logic [7:0]  SPR_RST  = 8'h7E
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic                       we,
  input  logic [REG_AW-1:0]          idx,
  input  logic [DW-1:0]              din,
  output logic [(1<<REG_AW)*DW-1:0]  regs
);

  localparam int unsigned NREG = 1 << REG_AW;

  for (genvar i = 0; i < NREG; i++) begin : g_reg
    localparam logic [DW-1:0] RST_VAL =
      (i == NAME_IDX) ? DW'(NAME_RST) :
      (i == SPR_IDX)  ? DW'(SPR_RST)  : '0;
    always_ff @(posedge clk) begin
      if (rst)                             regs[i*DW +: DW] <= RST_VAL;
      else if (we && idx == REG_AW'(i))    regs[i*DW +: DW] <= din;
    end
  end

endmodule

// File: rtl/vdp_cpu_port.sv
module vdp_cpu_port
  import vdp_port_pkg::*;
#(
  parameter int unsigned VRAM_AW = 11
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        ctrl_wr,
  input  logic        ctrl_rd,
  input  logic        data_wr,
  input  logic        data_rd,
  input  logic [7:0]  wdata,
  output logic [7:0]  rdata,
  output logic        rvalid,
  input  logic        frame_set,
  input  logic        line_set,
  input  logic        coll_set,
  output logic        irq,
  input  logic [3:0]  reg_sel,
  output logic [7:0]  reg_val,
  output logic [13:0] name_base,
  output logic [13:0] sprite_base
);

  localparam int unsigned DW       = 8;
  localparam int unsigned PTR_W    = 14;
  localparam int unsigned PAL_AW   = 5;
  localparam int unsigned PAL_DW   = 6;
  localparam int unsigned REG_AW   = 4;
  localparam int unsigned NREG     = 1 << REG_AW;
  localparam int unsigned NFLAG    = 3;
  localparam int unsigned IRQEN_IX = 1;
  localparam int unsigned IRQEN_B  = 5;
  localparam int unsigned NAME_IX  = 2;
  localparam int unsigned SPR_IX   = 5;
  localparam int unsigned NAME_LSB = 11;
  localparam int unsigned SPR_LSB  = 8;
  localparam int unsigned STAT_PAD = DW - NFLAG;

  logic [PTR_W-1:0]   vram_ptr;
  logic [PAL_AW-1:0]  pal_ptr;
  logic               pal_sel;
  logic               pending;
  logic               reg_we;
  logic [REG_AW-1:0]  reg_idx;
  logic [DW-1:0]      reg_data;
  logic [NREG*DW-1:0] regs;
  logic [DW-1:0]      vram_q;
  logic [PAL_DW-1:0]  pal_q;
  logic [NFLAG-1:0]   flag_q;
  logic [NFLAG-1:0]   snap_q;
  logic               irq_en;
  logic               unused_ptr_hi;
  rd_src_e            src_q;

  vdp_cmd_decoder #(
    .DW(DW), .PTR_W(PTR_W), .PAL_AW(PAL_AW), .REG_AW(REG_AW)
  ) u_dec (
    .clk(clk), .rst(rst),
    .ctrl_wr(ctrl_wr), .ctrl_rd(ctrl_rd),
    .data_wr(data_wr), .data_rd(data_rd),
    .wdata(wdata),
    .vram_ptr(vram_ptr), .pal_ptr(pal_ptr), .pal_sel(pal_sel),
    .pending(pending),
    .reg_we(reg_we), .reg_idx(reg_idx), .reg_data(reg_data)
  );

  // Pointer bits above the storage depth only select a mirror
  assign unused_ptr_hi = ^vram_ptr;

  vdp_bram #(.AW(VRAM_AW), .DW(DW)) u_vram (
    .clk(clk),
    .we(data_wr & ~pal_sel),
    .re(data_rd & ~pal_sel),
    .addr(vram_ptr[VRAM_AW-1:0]),
    .din(wdata),
    .q(vram_q)
  );

  vdp_bram #(.AW(PAL_AW), .DW(PAL_DW)) u_pal (
    .clk(clk),
    .we(data_wr & pal_sel),
    .re(data_rd & pal_sel),
    .addr(pal_ptr),
    .din(wdata[PAL_DW-1:0]),
    .q(pal_q)
  );

  // Flag order, MSB first: frame, line, collision
  vdp_status_flags #(.NFLAG(NFLAG)) u_flags (
    .clk(clk), .rst(rst),
    .rd(ctrl_rd),
    .set_in({frame_set, line_set, coll_set}),
    .clr_on_rd(3'b110),
    .flag_q(flag_q),
    .snap_q(snap_q)
  );

  vdp_reg_bank #(
    .DW(DW), .REG_AW(REG_AW), .NAME_IDX(NAME_IX), .SPR_IDX(SPR_IX),
    .NAME_RST(8'h0E), .SPR_RST(8'h7E)
  ) u_regs (
    .clk(clk), .rst(rst),
    .we(reg_we), .idx(reg_idx), .din(reg_data),
    .regs(regs)
  );

  assign irq_en      = regs[IRQEN_IX*DW + IRQEN_B];
  assign irq         = flag_q[NFLAG-1] & irq_en;
  assign name_base   = {regs[NAME_IX*DW+1 +: 3], {NAME_LSB{1'b0}}};
  assign sprite_base = {regs[SPR_IX*DW+1 +: 6], {SPR_LSB{1'b0}}};

  always_ff @(posedge clk) begin
    if (rst) begin
      rvalid  <= 1'b0;
      src_q   <= SRC_STAT;
      reg_val <= '0;
    end else begin
      rvalid  <= data_rd | ctrl_rd;
      reg_val <= regs[reg_sel*DW +: DW];
      if (data_rd)      src_q <= pal_sel ? SRC_PAL : SRC_VRAM;
      else if (ctrl_rd) src_q <= SRC_STAT;
    end
  end

  always_comb begin
    case (src_q)
      SRC_VRAM: rdata = vram_q;
      SRC_PAL:  rdata = {{(DW-PAL_DW){1'b0}}, pal_q};
      default:  rdata = {snap_q, {STAT_PAD{1'b0}}};
    endcase
  end

endmodule

// File: rtl/vdp_cpu_port_checker.sv
module vdp_cpu_port_checker (
  input logic       clk,
  input logic       rst,
  input logic       ctrl_wr,
  input logic       ctrl_rd,
  input logic       data_wr,
  input logic       data_rd,
  input logic [7:0] rdata,
  input logic       rvalid,
  input logic       frame_set,
  input logic       line_set,
  input logic       irq,
  input logic [2:0] flag_q,
  input logic       pal_sel,
  input logic       pending,
  input logic       irq_en
);

  assert_one_strobe: assert property (@(posedge clk) disable iff (rst)
    $onehot0({ctrl_wr, ctrl_rd, data_wr, data_rd}));

  assert_rvalid_follows_read_R12: assert property (@(posedge clk) disable iff (rst)
    (data_rd || ctrl_rd) |=> rvalid);

  assert_rvalid_quiet_R12: assert property (@(posedge clk) disable iff (rst)
    !(data_rd || ctrl_rd) |=> !rvalid);

  assert_status_low_bits_R8: assert property (@(posedge clk) disable iff (rst)
    ctrl_rd |=> (rdata[4:0] == 5'b0));

  assert_frame_cleared_R8: assert property (@(posedge clk) disable iff (rst)
    (ctrl_rd && !frame_set) |=> !flag_q[2]);

  assert_set_wins_R9: assert property (@(posedge clk) disable iff (rst)
    (ctrl_rd && line_set) |=> flag_q[1]);

  assert_colour_width_R5: assert property (@(posedge clk) disable iff (rst)
    (data_rd && pal_sel) |=> (rdata[7:6] == 2'b00));

  assert_discard_pending_R7: assert property (@(posedge clk) disable iff (rst)
    (data_rd || data_wr || ctrl_rd) |=> !pending);

  assert_irq_raise_R11: assert property (@(posedge clk) disable iff (rst)
    (frame_set && irq_en && !ctrl_wr) |=> irq);

  assert_irq_drop_R11: assert property (@(posedge clk) disable iff (rst)
    (ctrl_rd && !frame_set) |=> !irq);

endmodule

bind vdp_cpu_port vdp_cpu_port_checker u_chk (
  .clk(clk), .rst(rst),
  .ctrl_wr(ctrl_wr), .ctrl_rd(ctrl_rd),
  .data_wr(data_wr), .data_rd(data_rd),
  .rdata(rdata), .rvalid(rvalid),
  .frame_set(frame_set), .line_set(line_set),
  .irq(irq), .flag_q(flag_q),
  .pal_sel(pal_sel), .pending(pending), .irq_en(irq_en)
);

// File: tb/vdp_cpu_port_test.sv
module vdp_cpu_port_test;

  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        ctrl_wr = 1'b0, ctrl_rd = 1'b0, data_wr = 1'b0, data_rd = 1'b0;
  logic [7:0]  wdata = '0;
  logic [7:0]  rdata;
  logic        rvalid;
  logic        frame_set = 1'b0, line_set = 1'b0, coll_set = 1'b0;
  logic        irq;
  logic [3:0]  reg_sel = '0;
  logic [7:0]  reg_val;
  logic [13:0] name_base, sprite_base;

  int checks = 0;
  int errors = 0;

  typedef struct { logic [7:0] val; string req; } exp_t;
  exp_t expq[$];

  always #(CLK_PERIOD/2) clk = ~clk;

  vdp_cpu_port uut (
    .clk(clk), .rst(rst),
    .ctrl_wr(ctrl_wr), .ctrl_rd(ctrl_rd), .data_wr(data_wr), .data_rd(data_rd),
    .wdata(wdata), .rdata(rdata), .rvalid(rvalid),
    .frame_set(frame_set), .line_set(line_set), .coll_set(coll_set),
    .irq(irq), .reg_sel(reg_sel), .reg_val(reg_val),
    .name_base(name_base), .sprite_base(sprite_base)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  // Monitor: pops one expectation per valid read byte
  always @(negedge clk) begin
    if (!rst && rvalid) begin
      if (expq.size() == 0) begin
        check(1'b0, "R12 unexpected rvalid", 1, 0);
      end else begin
        exp_t e;
        e = expq.pop_front();
        check(rdata == e.val, e.req, rdata, e.val);
      end
    end
  end

  task automatic pulse_strobe(input int kind, input logic [7:0] b,
                              input bit fs, input bit ls);
    @(negedge clk);
    wdata = b; frame_set = fs; line_set = ls;
    case (kind)
      0: ctrl_wr = 1'b1;
      1: ctrl_rd = 1'b1;
      2: data_wr = 1'b1;
      default: data_rd = 1'b1;
    endcase
    @(negedge clk);
    ctrl_wr = 1'b0; ctrl_rd = 1'b0; data_wr = 1'b0; data_rd = 1'b0;
    frame_set = 1'b0; line_set = 1'b0;
  endtask

  task automatic cwr(input logic [7:0] b);  pulse_strobe(0, b, 0, 0); endtask
  task automatic cmd(input logic [7:0] b1, input logic [7:0] b2); cwr(b1); cwr(b2); endtask
  task automatic dwr(input logic [7:0] b);  pulse_strobe(2, b, 0, 0); endtask

  task automatic drd(input logic [7:0] exp, input string req);
    exp_t e; e.val = exp; e.req = req;
    expq.push_back(e);
    pulse_strobe(3, 8'h00, 0, 0);
  endtask

  task automatic srd(input logic [7:0] exp, input string req, input bit fs, input bit ls);
    exp_t e; e.val = exp; e.req = req;
    expq.push_back(e);
    pulse_strobe(1, 8'h00, fs, ls);
  endtask

  task automatic pulse_flag(input bit fs, input bit ls, input bit cs);
    @(negedge clk);
    frame_set = fs; line_set = ls; coll_set = cs;
    @(negedge clk);
    frame_set = 1'b0; line_set = 1'b0; coll_set = 1'b0;
  endtask

  task automatic read_reg(input logic [3:0] n, input logic [7:0] exp, input string req);
    @(negedge clk); reg_sel = n;
    @(negedge clk); @(negedge clk);
    check(reg_val == exp, req, reg_val, exp);
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    check(1'b0, "watchdog expired", 0, 1);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R10 reset state
    check(name_base == 14'h3800, "R10 name base", name_base, 14'h3800);
    check(sprite_base == 14'h3F00, "R10 sprite base", sprite_base, 14'h3F00);
    check(irq == 1'b0, "R10 irq", irq, 0);
    check(rvalid == 1'b0, "R12 idle rvalid", rvalid, 0);
    read_reg(4'd2, 8'h0E, "R10 reg2");
    read_reg(4'd5, 8'h7E, "R10 reg5");
    read_reg(4'd9, 8'h00, "R10 reg9");
    srd(8'h00, "R10 R8 status after reset", 0, 0);

    // R2 R6 video memory write then read
    cmd(8'h00, 8'h40);
    dwr(8'h11); dwr(8'h22); dwr(8'h33);
    cmd(8'h00, 8'h00);
    drd(8'h11, "R2 op00 read 0");
    drd(8'h22, "R6 increment 1");
    drd(8'h33, "R6 increment 2");
    cmd(8'h01, 8'h40);
    drd(8'h22, "R2 low byte select");

    // R1 R7 lone first byte discarded by data access
    cmd(8'h00, 8'h40);
    cwr(8'h02);
    drd(8'h11, "R1 old pointer kept");
    cwr(8'h40);
    drd(8'h22, "R7 data access discards staged byte");
    // R7 status read discards staged byte; pointer now 2
    cwr(8'h00);
    srd(8'h00, "R7 status during pending", 0, 0);
    cwr(8'h40);
    drd(8'h33, "R7 status read discards staged byte");

    // R3 register writes
    cmd(8'h5A, 8'h87);
    read_reg(4'd7, 8'h5A, "R3 reg7 write");
    cmd(8'hC3, 8'h8F);
    read_reg(4'd15, 8'hC3, "R3 reg15 write");
    cmd(8'h06, 8'h82);
    @(negedge clk);
    check(name_base == 14'h1800, "R3 name base", name_base, 14'h1800);
    cmd(8'h42, 8'h85);
    @(negedge clk);
    check(sprite_base == 14'h2100, "R3 sprite base", sprite_base, 14'h2100);

    // R4 R5 R6 colour table with wrap
    cmd(8'h1E, 8'hC0);
    dwr(8'h3F); dwr(8'h15); dwr(8'h2A);
    cmd(8'h1E, 8'hC0);
    drd(8'h3F, "R4 colour entry 30");
    drd(8'h15, "R6 colour entry 31");
    drd(8'h2A, "R6 colour wrap to 0");
    cmd(8'h05, 8'hC0);
    dwr(8'hFF);
    cmd(8'h05, 8'hC0);
    drd(8'h3F, "R5 six bit entry");

    // R13 selection follows last complete command
    cmd(8'h00, 8'h40);
    drd(8'h11, "R13 video memory untouched by colour writes");
    cmd(8'h00, 8'hC0);
    cmd(8'h00, 8'h81);
    drd(8'h22, "R13 register command returns to video memory");

    // R6 video pointer wrap
    cmd(8'hFF, 8'h7F);
    dwr(8'hA5); dwr(8'h5A);
    cmd(8'h00, 8'h40);
    drd(8'h5A, "R6 wrap 3FFF to 0000");
    cmd(8'hFF, 8'h7F);
    drd(8'hA5, "R6 top address");

    // R8 flags
    pulse_flag(0, 1, 1);
    srd(8'h60, "R8 line and collision", 0, 0);
    srd(8'h20, "R8 collision held, line cleared", 0, 0);

    // R11 interrupt
    pulse_flag(1, 0, 0);
    @(negedge clk);
    check(irq == 1'b0, "R11 irq masked", irq, 0);
    cmd(8'h20, 8'h81);
    @(negedge clk);
    check(irq == 1'b1, "R11 irq on enable", irq, 1);
    srd(8'hA0, "R8 frame flag", 0, 0);
    @(negedge clk);
    check(irq == 1'b0, "R11 irq after status read", irq, 0);
    pulse_flag(1, 0, 0);
    @(negedge clk);
    check(irq == 1'b1, "R11 irq on frame pulse", irq, 1);
    srd(8'hA0, "R8 frame flag again", 0, 0);

    // R9 set pulse coinciding with status read
    srd(8'h20, "R9 read with frame pulse shows prior", 1, 0);
    @(negedge clk);
    check(irq == 1'b1, "R9 R11 frame stays set", irq, 1);
    srd(8'hA0, "R9 frame set after overlap", 0, 0);
    pulse_flag(0, 1, 0);
    srd(8'h60, "R9 line set before overlap", 0, 1);
    srd(8'h60, "R9 line kept by overlap", 0, 0);
    srd(8'h20, "R9 line cleared later", 0, 0);

    repeat (3) @(negedge clk);
    check(rvalid == 1'b0, "R12 rvalid idle", rvalid, 0);
    check(expq.size() == 0, "R12 all reads returned", expq.size(), 0);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule